// File: doc/BRIEF.md
# Supply Start-Up and Restart Sequencer

This block supervises the power-up of a switched-mode converter's control supply. It reads digital comparator flags: bulk input above the start level, control-supply voltage above the turn-on level, below the turn-off level and below the restart level, plus brown-out and thermal comparators and a fault request. From these it decides when the high-voltage start-up charger runs and at which rate it charges. It also decides when the power switch may operate and which current-limit code the soft-start ramp presents.

A normal cycle runs like this. The charger fills the supply capacitor. When the supply reaches the turn-on level the charger stops and switching begins, with the current limit ramping up from zero. If the supply then sags below the turn-off level, switching stops and the charger stays off until the supply has decayed below the much lower restart level. When a fault has stopped the converter, the next charge phase uses the reduced rate, so repeated restart attempts are spread far apart.

Top module: `supply_start_seq`

## Requirements
- R1: After reset the charger is off, switching is off, the reduced-rate select is 0 and the current-limit code is 0.
- R2: The charger is enabled only in the charge phase and only while `bulk_ok` is 1. From idle, the charge phase starts only when `bulk_ok` is 1. If `bulk_ok` drops during charging, the sequencer returns to idle.
- R3: In the charge phase, `vdd_above_on` moves the sequencer to the run phase on the next clock edge. The charger turns off at that edge, and switching starts if no block is active. Charger and switching are never enabled together.
- R4: In the run phase, `vdd_below_off` stops switching at the next edge. The charger then stays off until `vdd_below_rst` is 1. At that point the sequencer charges if `bulk_ok` is 1 and otherwise goes idle.
- R5: A fault request in the run phase latches a fault that disables switching from the next edge. Leaving the run phase on `vdd_below_off` clears the latch. If a fault was latched, the following charge phase has `slow_charge` = 1. `slow_charge` returns to 0 when the run phase is entered.
- R6: Whenever switching becomes enabled, `ilim_code` starts at 0 and rises by 1 every STEP = SS_CYCLES/(2^CODE_W-1) cycles until it reaches 2^CODE_W-1, where it holds. While switching is disabled, the code is 0.
- R7: `br_low` blocks switching from the next edge. The block stays active, even after `br_low` returns to 0, until `br_high` is 1. The block is active after reset. It is not latched beyond `br_high`.
- R8: `temp_hot` blocks switching from the next edge. The block persists until `temp_cool` is 1.
- R9: When switching is re-enabled after a brown-out or thermal block, the soft-start ramp begins again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bulk_ok | input | 1 | Bulk input above start level |
| vdd_above_on | input | 1 | Supply above turn-on level |
| vdd_below_off | input | 1 | Supply below turn-off level |
| vdd_below_rst | input | 1 | Supply below restart level |
| br_low | input | 1 | Brown-out input below lower threshold |
| br_high | input | 1 | Brown-out input above upper threshold |
| temp_hot | input | 1 | Die temperature above shutdown level |
| temp_cool | input | 1 | Die temperature below release level |
| fault_req | input | 1 | Fault request from protection logic |
| charger_en | output | 1 | High-voltage start-up charger enable |
| slow_charge | output | 1 | Reduced charge rate select |
| switch_en | output | 1 | Power switch enable |
| ilim_code | output | CODE_W | Soft-start current-limit code |

## Verification
Every input is registered once before it acts, so phase changes, blocks and the fault latch show at the outputs one cycle after the input changes. The exception is `charger_en`, which also follows `bulk_ok` within the same cycle. The ramp code reaches value k exactly k·STEP cycles after `switch_en` rises. The bench drives inputs just after a rising edge. It compares every output against a behavioural reference at each falling edge. Its directed checks sample one cycle after the stimulus edge, which is where each result is due.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CHARGE = 2'd1,
    PH_RUN    = 2'd2,
    PH_DRAIN  = 2'd3
  } phase_t;
endpackage

// File: rtl/seq_guard.sv
module seq_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic br_low,
  input  logic br_high,
  input  logic temp_hot,
  input  logic temp_cool,
  output logic block_o
);
  logic bo_q, bo_d, th_q, th_d;

  always_comb begin
    bo_d = bo_q;
    if (br_low)        bo_d = 1'b1;
    else if (br_high)  bo_d = 1'b0;
    th_d = th_q;
    if (temp_hot)      th_d = 1'b1;
    else if (temp_cool) th_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_q <= 1'b1;
      th_q <= 1'b0;
    end else begin
      bo_q <= bo_d;
      th_q <= th_d;
    end
  end

  assign block_o = bo_q | th_q;

  assert_brownout_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_low |=> bo_q);
  assert_thermal_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    temp_hot |=> th_q);
endmodule

// File: rtl/seq_ramp.sv
module seq_ramp #(
  parameter int SS_CYCLES = 850000,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int STEP_RAW = SS_CYCLES / CODE_MAX;
  localparam int STEP     = (STEP_RAW < 1) ? 1 : STEP_RAW;
  localparam int CNT_W    = $clog2(STEP + 1);
  localparam logic [CODE_W-1:0] MAXC = CODE_W'(CODE_MAX);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(STEP - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              cnt_en;

  assign cnt_en = run_i && (code_q != MAXC);

  always_comb begin
    cnt_d  = cnt_q;
    code_d = code_q;
    if (!run_i) begin
      cnt_d  = '0;
      code_d = '0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        code_d = code_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      code_q <= code_d;
    end
  end

  assign code_o = run_i ? code_q : '0;

  assert_ramp_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i)) |-> (code_o >= $past(code_o)));
  assert_ramp_starts_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (code_o == '0));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import supply_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bulk_ok,
  input  logic vdd_above_on,
  input  logic vdd_below_off,
  input  logic vdd_below_rst,
  input  logic fault_req,
  output phase_t phase_o,
  output logic fault_o,
  output logic slow_o
);
  phase_t ph_q, ph_d;
  logic   flt_q, flt_d, slow_q, slow_d;

  always_comb begin
    ph_d   = ph_q;
    flt_d  = flt_q;
    slow_d = slow_q;
    unique case (ph_q)
      PH_IDLE:   if (bulk_ok) ph_d = PH_CHARGE;
      PH_CHARGE: begin
        if (vdd_above_on) begin
          ph_d   = PH_RUN;
          slow_d = 1'b0;
        end else if (!bulk_ok) begin
          ph_d = PH_IDLE;
        end
      end
      PH_RUN: begin
        if (vdd_below_off) begin
          ph_d   = PH_DRAIN;
          slow_d = flt_q | fault_req;
          flt_d  = 1'b0;
        end else if (fault_req) begin
          flt_d = 1'b1;
        end
      end
      PH_DRAIN:  if (vdd_below_rst) ph_d = bulk_ok ? PH_CHARGE : PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      flt_q  <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      flt_q  <= flt_d;
      slow_q <= slow_d;
    end
  end

  assign phase_o = ph_q;
  assign fault_o = flt_q;
  assign slow_o  = slow_q;

  assert_run_from_charge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RUN && $past(ph_q) != PH_RUN) |-> ($past(ph_q) == PH_CHARGE && $past(vdd_above_on)));
  assert_drain_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_DRAIN && !$past(vdd_below_rst)) |-> (ph_q == PH_DRAIN));
  assert_fault_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DRAIN) |-> !flt_q);
endmodule

// File: rtl/supply_start_seq.sv
module supply_start_seq
  import supply_seq_pkg::*;
#(
  parameter int SS_CYCLES = 850000,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bulk_ok,
  input  logic              vdd_above_on,
  input  logic              vdd_below_off,
  input  logic              vdd_below_rst,
  input  logic              br_low,
  input  logic              br_high,
  input  logic              temp_hot,
  input  logic              temp_cool,
  input  logic              fault_req,
  output logic              charger_en,
  output logic              slow_charge,
  output logic              switch_en,
  output logic [CODE_W-1:0] ilim_code
);
  phase_t phase;
  logic   fault_l, blocked;

  seq_fsm u_fsm (
    .clk, .rst_n, .bulk_ok, .vdd_above_on, .vdd_below_off, .vdd_below_rst,
    .fault_req, .phase_o(phase), .fault_o(fault_l), .slow_o(slow_charge)
  );

  seq_guard u_guard (
    .clk, .rst_n, .br_low, .br_high, .temp_hot, .temp_cool, .block_o(blocked)
  );

  assign charger_en = (phase == PH_CHARGE) && bulk_ok;
  assign switch_en  = (phase == PH_RUN) && !blocked && !fault_l;

  seq_ramp #(.SS_CYCLES(SS_CYCLES), .CODE_W(CODE_W)) u_ramp (
    .clk, .rst_n, .run_i(switch_en), .code_o(ilim_code)
  );

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(charger_en && switch_en));
  assert_charger_needs_bulk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    charger_en |-> bulk_ok);
  assert_fault_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_req) && $past(switch_en) && !$past(vdd_below_off)) |-> !switch_en);
endmodule

// File: tb/test_supply_start_seq.sv
module test_supply_start_seq;
  localparam int SS = 28;
  localparam int CW = 3;
  localparam int CMAX = 7;
  localparam int STEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bulk_ok = 0, vdd_above_on = 0, vdd_below_off = 1, vdd_below_rst = 1;
  logic br_low = 0, br_high = 0, temp_hot = 0, temp_cool = 0, fault_req = 0;
  logic charger_en, slow_charge, switch_en;
  logic [CW-1:0] ilim_code;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  supply_start_seq #(.SS_CYCLES(SS), .CODE_W(CW)) i_supply_start_seq (
    .clk, .rst_n, .bulk_ok, .vdd_above_on, .vdd_below_off, .vdd_below_rst,
    .br_low, .br_high, .temp_hot, .temp_cool, .fault_req,
    .charger_en, .slow_charge, .switch_en, .ilim_code
  );

  // Behavioural reference: phases 0 idle, 1 charging, 2 running, 3 draining
  int  m_ph = 0, m_cnt = 0, m_code = 0;
  bit  m_flt = 0, m_slow = 0, m_bo = 1, m_th = 0;

  function automatic bit exp_sw();
    return (m_ph == 2) && !m_bo && !m_th && !m_flt;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_code = 0; m_flt = 0; m_slow = 0; m_bo = 1; m_th = 0;
    end else begin
      bit run;
      run = exp_sw();
      if (!run) begin m_cnt = 0; m_code = 0; end
      else if (m_code < CMAX) begin
        m_cnt++;
        if (m_cnt == STEP) begin m_cnt = 0; m_code++; end
      end
      if (br_low) m_bo = 1; else if (br_high) m_bo = 0;
      if (temp_hot) m_th = 1; else if (temp_cool) m_th = 0;
      case (m_ph)
        0: if (bulk_ok) m_ph = 1;
        1: if (vdd_above_on) begin m_ph = 2; m_slow = 0; end
           else if (!bulk_ok) m_ph = 0;
        2: if (vdd_below_off) begin m_ph = 3; m_slow = m_flt || fault_req; m_flt = 0; end
           else if (fault_req) m_flt = 1;
        default: if (vdd_below_rst) m_ph = bulk_ok ? 1 : 0;
      endcase
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(charger_en, (m_ph == 1) && bulk_ok, "R2 charger vs model");
    chk(switch_en, exp_sw(), "R3 switch vs model");
    chk(slow_charge, m_slow, "R5 slow rate vs model");
    chk(ilim_code, exp_sw() ? m_code : 0, "R6 ramp code vs model");
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    #1;
    chk(charger_en, 0, "R1 reset charger");
    chk(switch_en, 0, "R1 reset switch");
    chk(ilim_code, 0, "R1 reset code");
    chk(slow_charge, 0, "R1 reset slow");
    rst_n = 1;
    tick(4);
    chk(charger_en, 0, "R2 idle without bulk");
    bulk_ok = 1; br_high = 1;
    tick(1); br_high = 0;
    tick(1);
    chk(charger_en, 1, "R2 charging with bulk");
    vdd_above_on = 1; vdd_below_off = 0; vdd_below_rst = 0;
    tick(1);
    chk(charger_en, 0, "R3 charger off at turn-on");
    chk(switch_en, 1, "R3 switching at turn-on");
    tick(STEP * CMAX + 4);
    chk(ilim_code, CMAX, "R6 ramp reaches full scale");
    br_low = 1; tick(1); br_low = 0;
    chk(switch_en, 0, "R7 brown-out blocks");
    tick(5);
    chk(switch_en, 0, "R7 block held until upper threshold");
    br_high = 1; tick(1); br_high = 0;
    chk(switch_en, 1, "R7 resumes above upper threshold");
    chk(ilim_code, 0, "R9 ramp restarts after brown-out");
    tick(STEP + 1);
    chk(ilim_code, 1, "R9 ramp first step");
    temp_hot = 1; tick(1); temp_hot = 0;
    chk(switch_en, 0, "R8 thermal blocks");
    tick(3);
    temp_cool = 1; tick(1); temp_cool = 0;
    chk(switch_en, 1, "R8 resumes when cool");
    tick(10);
    fault_req = 1; tick(1); fault_req = 0;
    chk(switch_en, 0, "R5 fault stops switching");
    vdd_above_on = 0;
    tick(4);
    vdd_below_off = 1; tick(1);
    chk(charger_en, 0, "R4 charger off while draining");
    tick(5);
    chk(charger_en, 0, "R4 waits for restart level");
    vdd_below_rst = 1; tick(1);
    chk(charger_en, 1, "R4 charging after restart level");
    chk(slow_charge, 1, "R5 reduced rate after fault");
    vdd_above_on = 1; vdd_below_off = 0; vdd_below_rst = 0; tick(1);
    chk(slow_charge, 0, "R5 rate cleared on start");
    chk(switch_en, 1, "R5 fault cleared on new start");
    tick(8);
    vdd_above_on = 0; vdd_below_off = 1; tick(1);
    chk(switch_en, 0, "R4 undervoltage stops switching");
    chk(slow_charge, 0, "R5 normal rate without fault");
    bulk_ok = 0; tick(2);
    vdd_below_rst = 1; tick(2);
    chk(charger_en, 0, "R2 stays idle with bulk low");
    bulk_ok = 1; tick(2);
    chk(charger_en, 1, "R2 charges once bulk returns");
    bulk_ok = 0; tick(1);
    chk(charger_en, 0, "R2 bulk loss stops charger");
    tick(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule